// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a CPU-side access path and a PCI host port. It turns a
CPU access that falls in the downstream configuration window into a type-0
configuration address. The low half of the CPU address is joined with the low
half of a mapping register to form a 32-bit composed address. In that address,
a one-hot field of device select bits gives the device number, and two further
bit fields give the function and the register. The block then issues one
configuration-cycle strobe that carries the address, the access width, the
direction and the write data.

CPU requests enter on a valid/ready channel. `cpu_ready` is high only while
the block is idle, so it holds one access at a time and any further request
waits on back-pressure. For a read, the host port returns data on a one-cycle
`host_rvalid` pulse. Every access finishes with one response on a valid/ready
channel. The response is held stable until `rsp_ready` is seen high at a clock
edge. Mapping-register bit 16 disables translation, which returns all ones.
Misaligned accesses and accesses with no device select bit set are rejected
with an error flag. Every access that reaches the host port also pulses a
clear for the bridge's received-abort status bits.

Top module: `cfgx_xlate`

## Requirements
- R1: The composed address takes bits [15:0] from `cpu_addr` and bits [31:16] from `map_reg[15:0]`.
- R2: The device number is the index of the lowest set bit among composed bits [31:11], where bit 11 gives device 0 and bit 31 gives device 20. Higher set bits are ignored.
- R3: The issued `host_addr` has bit 31 set and bits [30:24] zero. `bus_num` sits at [23:16], the device at [15:11], composed bits [10:8] at [10:8] as the function, composed bits [7:2] at [7:2] as the register, and bits [1:0] are zero.
- R4: When `map_reg[16]` is 1 and the access is aligned, no strobe is issued and `rsp_err` is 0. A read returns all ones at its width: 0xFF, 0xFFFF or 0xFFFFFFFF. A write returns 0.
- R5: An aligned, enabled access whose composed bits [31:11] are all zero issues no strobe and responds with `rsp_err`=1.
- R6: The size codes are 0 for byte, 1 for halfword, 2 for word, and 3 is invalid. An access is misaligned if it is a halfword with address bit 0 set or a word with address bits [1:0] not zero. A misaligned access or size code 3 issues no strobe and responds with `rsp_err`=1. This holds even when `map_reg[16]` is set.
- R7: A translated access raises `host_req` for exactly one cycle, in the cycle after acceptance. `host_write`, `host_size` and `host_wdata` carry the CPU request. `abort_clr` pulses in the same cycle as `host_req` and in no other cycle.
- R8: A translated read returns `host_rdata` zero-extended from its low 8, 16 or 32 bits according to the size. A write returns 0.
- R9: `cpu_ready` and `rsp_valid` are never high together. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` and `rsp_err` stay unchanged.
- R10: After reset, `cpu_ready` is 1 and `rsp_valid`, `host_req` and `abort_clr` are 0.
- R11: Rejected reads (R5, R6) return all ones at their width, with size code 3 treated as a word. Rejected writes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Block idle and able to accept a request |
| cpu_write | input | 1 | 1 for write, 0 for read |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | LO_W | Low CPU address bits in the window |
| cpu_wdata | input | 32 | Write data |
| map_reg | input | 32 | Mapping register: [15:0] upper address half, [16] disable |
| bus_num | input | BUS_W | Bus number placed in the output address |
| host_req | output | 1 | One-cycle configuration cycle strobe |
| host_addr | output | 32 | Configuration address, bit 31 is the enable |
| host_write | output | 1 | Direction of the cycle |
| host_size | output | 2 | Width of the cycle |
| host_wdata | output | 32 | Write data of the cycle |
| abort_clr | output | 1 | Pulse that clears the received master/target abort status |
| host_rvalid | input | 1 | Read data valid pulse from the host port |
| host_rdata | input | 32 | Read data from the host port |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Access rejected |

## Verification
The bench uses addresses in which several device select bits are set, some in the CPU half and some in the mapping half. A priority encoder that picked the highest set bit would report the wrong device there. It also checks the order of the rejection rules: a misaligned access with translation disabled must answer with an error and not with all ones, and a design that checked the disable bit first would fail that. Byte reads at offsets 1 to 3 catch a design that keeps address bits [1:0] in the register field or that does not mask the returned data to its width. Responses held under back-pressure catch a response register that is overwritten while it is still waiting.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int CFG_W     = 32;
  localparam int IDSEL_LSB = 11;
  localparam int IDSEL_W   = CFG_W - IDSEL_LSB;
  localparam int DEV_W     = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    CL_OK    = 2'd0,
    CL_UNSUP = 2'd1,
    CL_ERR   = 2'd2
  } acc_class_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_e;

  function automatic logic [CFG_W-1:0] fill_ones(acc_size_e sz);
    case (sz)
      SZ_BYTE: fill_ones = 32'h0000_00FF;
      SZ_HALF: fill_ones = 32'h0000_FFFF;
      default: fill_ones = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [CFG_W-1:0] trim_data(logic [CFG_W-1:0] d, acc_size_e sz);
    case (sz)
      SZ_BYTE: trim_data = {24'h0, d[7:0]};
      SZ_HALF: trim_data = {16'h0, d[15:0]};
      default: trim_data = d;
    endcase
  endfunction

endpackage

// File: rtl/cfgx_lsb_find.sv
module cfgx_lsb_find #(
  parameter int W  = 21,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          none
);

  logic [W-1:0] seen;
  logic [W-1:0] first;

  assign seen[0]  = vec[0];
  assign first[0] = vec[0];

  genvar g;
  generate
    for (g = 1; g < W; g++) begin : g_chain
      assign seen[g]  = seen[g-1] | vec[g];
      assign first[g] = vec[g] & ~seen[g-1];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end

  assign none = ~seen[W-1];

endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int LO_W    = 16,
  parameter int BUS_W   = 8,
  parameter int DIS_BIT = 16
) (
  input  logic [LO_W-1:0]  lo_addr,
  input  acc_size_e        size,
  input  logic [CFG_W-1:0] map_reg,
  input  logic [BUS_W-1:0] bus,
  output logic [CFG_W-1:0] cfg_addr,
  output acc_class_e       cls
);

  localparam int HI_W  = CFG_W - LO_W;
  localparam int PAD_W = 15 - BUS_W;

  logic [CFG_W-1:0]   composed;
  logic [IDSEL_W-1:0] idsel;
  logic [DEV_W-1:0]   dev;
  logic               no_dev;
  logic               misaligned;

  assign composed = {map_reg[HI_W-1:0], lo_addr};
  assign idsel    = composed[CFG_W-1:IDSEL_LSB];

  cfgx_lsb_find #(.W(IDSEL_W), .IW(DEV_W)) u_find (
    .vec  (idsel),
    .idx  (dev),
    .none (no_dev)
  );

  always_comb begin
    case (size)
      SZ_HALF: misaligned = lo_addr[0];
      SZ_WORD: misaligned = |lo_addr[1:0];
      SZ_BAD:  misaligned = 1'b1;
      default: misaligned = 1'b0;
    endcase
  end

  always_comb begin
    if (misaligned)              cls = CL_ERR;
    else if (map_reg[DIS_BIT])   cls = CL_UNSUP;
    else if (no_dev)             cls = CL_ERR;
    else                         cls = CL_OK;
  end

  assign cfg_addr = {1'b1, {PAD_W{1'b0}}, bus, dev, composed[10:8], composed[7:2], 2'b00};

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  output logic             cpu_ready,
  input  logic             cpu_write,
  input  acc_size_e        cpu_size,
  input  logic [CFG_W-1:0] cpu_wdata,
  input  logic [CFG_W-1:0] dec_addr,
  input  acc_class_e       dec_cls,
  output logic             host_req,
  output logic [CFG_W-1:0] host_addr,
  output logic             host_write,
  output acc_size_e        host_size,
  output logic [CFG_W-1:0] host_wdata,
  output logic             abort_clr,
  input  logic             host_rvalid,
  input  logic [CFG_W-1:0] host_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CFG_W-1:0] rsp_rdata,
  output logic             rsp_err
);

  seq_state_e       state;
  logic [CFG_W-1:0] addr_q;
  logic             wr_q;
  acc_size_e        size_q;
  logic [CFG_W-1:0] wdata_q;
  logic [CFG_W-1:0] rdata_q;
  logic             err_q;
  logic             accept;

  assign accept = (state == ST_IDLE) && cpu_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      size_q  <= SZ_BYTE;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= dec_addr;
            wr_q    <= cpu_write;
            size_q  <= cpu_size;
            wdata_q <= cpu_wdata;
            err_q   <= (dec_cls == CL_ERR);
            rdata_q <= (cpu_write || dec_cls == CL_OK) ? '0 : fill_ones(cpu_size);
            state   <= (dec_cls == CL_OK) ? ST_ISSUE : ST_RESP;
          end
        end
        ST_ISSUE: state <= wr_q ? ST_RESP : ST_WAIT;
        ST_WAIT: begin
          if (host_rvalid) begin
            rdata_q <= trim_data(host_rdata, size_q);
            state   <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready  = (state == ST_IDLE);
  assign host_req   = (state == ST_ISSUE);
  assign abort_clr  = (state == ST_ISSUE);
  assign host_addr  = addr_q;
  assign host_write = wr_q;
  assign host_size  = size_q;
  assign host_wdata = wdata_q;
  assign rsp_valid  = (state == ST_RESP);
  assign rsp_rdata  = rdata_q;
  assign rsp_err    = err_q;

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
  import cfgx_pkg::*;
#(
  parameter int LO_W    = 16,
  parameter int BUS_W   = 8,
  parameter int DIS_BIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  output logic             cpu_ready,
  input  logic             cpu_write,
  input  logic [1:0]       cpu_size,
  input  logic [LO_W-1:0]  cpu_addr,
  input  logic [31:0]      cpu_wdata,
  input  logic [31:0]      map_reg,
  input  logic [BUS_W-1:0] bus_num,
  output logic             host_req,
  output logic [31:0]      host_addr,
  output logic             host_write,
  output logic [1:0]       host_size,
  output logic [31:0]      host_wdata,
  output logic             abort_clr,
  input  logic             host_rvalid,
  input  logic [31:0]      host_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_err
);

  acc_size_e        size_in;
  acc_size_e        size_out;
  acc_class_e       cls;
  logic [CFG_W-1:0] dec_addr;

  assign size_in   = acc_size_e'(cpu_size);
  assign host_size = size_out;

  cfgx_decode #(.LO_W(LO_W), .BUS_W(BUS_W), .DIS_BIT(DIS_BIT)) u_decode (
    .lo_addr  (cpu_addr),
    .size     (size_in),
    .map_reg  (map_reg),
    .bus      (bus_num),
    .cfg_addr (dec_addr),
    .cls      (cls)
  );

  cfgx_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_valid   (cpu_valid),
    .cpu_ready   (cpu_ready),
    .cpu_write   (cpu_write),
    .cpu_size    (size_in),
    .cpu_wdata   (cpu_wdata),
    .dec_addr    (dec_addr),
    .dec_cls     (cls),
    .host_req    (host_req),
    .host_addr   (host_addr),
    .host_write  (host_write),
    .host_size   (size_out),
    .host_wdata  (host_wdata),
    .abort_clr   (abort_clr),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err)
  );

endmodule

// File: rtl/cfgx_xlate_chk.sv
module cfgx_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_valid,
  input logic        cpu_ready,
  input logic        host_req,
  input logic [31:0] host_addr,
  input logic        abort_clr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        rsp_err
);

  // R7: the strobe lasts a single cycle
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |=> !host_req);

  // R7: a strobe only follows an accepted request
  p_req_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> $past(cpu_valid && cpu_ready));

  // R7: status clear pulses together with the strobe
  p_clr_with_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_clr == host_req);

  // R3: issued address carries the enable and zero fill
  p_addr_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> (host_addr[31] && host_addr[30:24] == 7'd0 && host_addr[1:0] == 2'd0));

  // R2: device number within the select field range
  p_dev_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> (host_addr[15:11] < 5'd21));

  // R9: no new request accepted while a response is pending
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ready && rsp_valid));

  // R9: response is held under back-pressure
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

endmodule

bind cfgx_xlate cfgx_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .host_req  (host_req),
  .host_addr (host_addr),
  .abort_clr (abort_clr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err)
);

// File: tb/test_cfgx_xlate.sv
module test_cfgx_xlate;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HOST_KEY = 32'h5EED_1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic        cpu_write = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] map_reg = '0;
  logic [7:0]  bus_num = '0;
  logic        host_req;
  logic [31:0] host_addr;
  logic        host_write;
  logic [1:0]  host_size;
  logic [31:0] host_wdata;
  logic        abort_clr;
  logic        host_rvalid = 1'b0;
  logic [31:0] host_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int checks = 0;
  int errors = 0;
  int req_count = 0;
  int pend = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] cap_addr = '0;
  logic [31:0] cap_wdata = '0;
  logic [1:0]  cap_size = '0;
  logic        cap_wr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_xlate i_cfgx_xlate (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_write(cpu_write), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .map_reg(map_reg), .bus_num(bus_num),
    .host_req(host_req), .host_addr(host_addr), .host_write(host_write),
    .host_size(host_size), .host_wdata(host_wdata), .abort_clr(abort_clr),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // host port model and per-cycle checks
  always @(negedge clk) begin
    cycles++;
    host_rvalid = 1'b0;
    if (rst_n) begin
      chk(!(cpu_ready && rsp_valid), "R9 ready/valid exclusive", {31'd0, rsp_valid}, 32'd0);
      chk(abort_clr == host_req, "R7 abort_clr with host_req", {31'd0, abort_clr}, {31'd0, host_req});
    end
    if (host_req) begin
      req_count++;
      cap_addr  = host_addr;
      cap_wdata = host_wdata;
      cap_size  = host_size;
      cap_wr    = host_write;
      if (!host_write) pend = 2;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        host_rvalid = 1'b1;
        host_rdata  = cap_addr ^ HOST_KEY;
      end
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  function automatic logic [31:0] ones_w(input logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF;
    if (sz == 2'd1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  // behavioural reference of one access
  task automatic ref_model(input logic [15:0] a, input logic [31:0] mp, input logic [7:0] bn,
                           input logic [1:0] sz, input bit wr, output int cls,
                           output logic [31:0] ea, output logic [31:0] ed, output bit ee);
    logic [31:0] comp;
    int dev;
    bit mis;
    comp = {mp[15:0], a};
    mis = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'd0);
    dev = -1;
    for (int i = 11; i < 32; i++) if (comp[i] && dev < 0) dev = i - 11;
    if (mis) cls = 2;
    else if (mp[16]) cls = 1;
    else if (dev < 0) cls = 2;
    else cls = 0;
    ea = 32'h8000_0000 | (32'(bn) << 16) | (32'(dev < 0 ? 0 : dev) << 11)
       | (32'(comp[10:8]) << 8) | (comp & 32'hFC);
    ee = (cls == 2);
    if (wr) ed = 32'h0;
    else if (cls != 0) ed = ones_w(sz);
    else ed = (ea ^ HOST_KEY) & ones_w(sz);
  endtask

  task automatic access(input logic [15:0] a, input logic [31:0] mp, input logic [7:0] bn,
                        input logic [1:0] sz, input bit wr, input logic [31:0] wd,
                        input int hold, input string tag);
    int cls;
    logic [31:0] ea, ed;
    bit ee;
    int start;
    int guard;
    logic [31:0] held_d;
    logic held_e;
    ref_model(a, mp, bn, sz, wr, cls, ea, ed, ee);
    @(negedge clk);
    chk(cpu_ready, {tag, " R9 ready when idle"}, {31'd0, cpu_ready}, 32'd1);
    start = req_count;
    cpu_addr = a; map_reg = mp; bus_num = bn; cpu_size = sz; cpu_write = wr; cpu_wdata = wd;
    cpu_valid = 1'b1;
    @(negedge clk);
    cpu_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    held_d = rsp_rdata;
    held_e = rsp_err;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == held_d && rsp_err == held_e, {tag, " R9 held response"},
          rsp_rdata, held_d);
    end
    chk(rsp_valid, {tag, " response present"}, {31'd0, rsp_valid}, 32'd1);
    chk(rsp_rdata == ed, {tag, " data"}, rsp_rdata, ed);
    chk(rsp_err == ee, {tag, " err"}, {31'd0, rsp_err}, {31'd0, ee});
    chk(req_count - start == (cls == 0 ? 1 : 0), {tag, " strobe count"},
        32'(req_count - start), (cls == 0) ? 32'd1 : 32'd0);
    if (cls == 0) begin
      chk(cap_addr == ea, {tag, " R3 address"}, cap_addr, ea);
      chk(cap_wr == wr && cap_size == sz, {tag, " R7 attributes"}, {29'd0, cap_wr, cap_size},
          {29'd0, wr, sz});
      if (wr) chk(cap_wdata == wd, {tag, " R7 write data"}, cap_wdata, wd);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && cpu_ready, {tag, " R9 back to idle"}, {30'd0, rsp_valid, cpu_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(cpu_ready == 1'b1, "R10 cpu_ready", {31'd0, cpu_ready}, 32'd1);
    chk(!rsp_valid && !host_req && !abort_clr, "R10 outputs idle",
        {29'd0, rsp_valid, host_req, abort_clr}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3: device select from mapping half
    access(16'h0304, 32'h0000_0002, 8'h00, 2'd2, 1'b0, 32'h0, 0, "R1 word read dev6");
    // R2: several select bits, lowest in the CPU half wins
    access(16'h0A14, 32'h0000_0105, 8'h3C, 2'd2, 1'b0, 32'h0, 0, "R2 lowest select bit");
    access(16'h1000, 32'h0000_00F0, 8'h01, 2'd1, 1'b0, 32'h0, 0, "R2 bit12 half read");
    // R2 R7: top device, halfword write
    access(16'h0002, 32'h0000_8000, 8'hFF, 2'd1, 1'b1, 32'hCAFE_BEEF, 0, "R2 dev20 write");
    // R8: byte reads at every offset
    for (int k = 0; k < 4; k++)
      access(16'h0740 + 16'(k), 32'h0000_0010, 8'h05, 2'd0, 1'b0, 32'h0, 0, "R8 byte read");
    access(16'h0812, 32'h0000_0000, 8'h02, 2'd1, 1'b0, 32'h0, 0, "R8 half read");
    access(16'h08FC, 32'h0000_0040, 8'h07, 2'd2, 1'b1, 32'h1234_5678, 0, "R7 word write");
    // R4: translation disabled
    access(16'h0803, 32'h0001_0000, 8'h00, 2'd0, 1'b0, 32'h0, 0, "R4 disabled byte");
    access(16'h0802, 32'h0001_0040, 8'h00, 2'd1, 1'b0, 32'h0, 0, "R4 disabled half");
    access(16'h0800, 32'h0001_0040, 8'h00, 2'd2, 1'b0, 32'h0, 0, "R4 disabled word");
    access(16'h0800, 32'h0001_0040, 8'h00, 2'd2, 1'b1, 32'h55, 0, "R4 disabled write");
    // R5: no select bit
    access(16'h0704, 32'h0000_0000, 8'h00, 2'd2, 1'b0, 32'h0, 0, "R5 no device read");
    access(16'h0704, 32'h0000_0000, 8'h00, 2'd0, 1'b1, 32'h1, 0, "R5 no device write");
    // R6 R11: misaligned and invalid sizes
    access(16'h0801, 32'h0000_0000, 8'h00, 2'd1, 1'b0, 32'h0, 0, "R6 R11 odd half");
    access(16'h0802, 32'h0000_0000, 8'h00, 2'd2, 1'b0, 32'h0, 0, "R6 R11 unaligned word");
    access(16'h0800, 32'h0000_0000, 8'h00, 2'd3, 1'b0, 32'h0, 0, "R6 R11 size code 3");
    access(16'h0803, 32'h0001_0000, 8'h00, 2'd2, 1'b0, 32'h0, 0, "R6 misalign beats disable");
    access(16'h0801, 32'h0000_0000, 8'h00, 2'd1, 1'b1, 32'h9, 0, "R6 R11 odd half write");
    // R9: back-pressure on responses
    access(16'h0C08, 32'h0000_0000, 8'h11, 2'd2, 1'b0, 32'h0, 4, "R9 held read");
    access(16'h0801, 32'h0000_0000, 8'h11, 2'd2, 1'b0, 32'h0, 3, "R9 held error");

    done = 1;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule